// File: doc/BRIEF.md
# Serial EEPROM Host Register Interface

This block lets a host reach a serial EEPROM through two 32-bit registers on a simple single-cycle register bus. The first register is a control word. It carries software-driven levels for the serial clock, the chip select and the serial data-out line, and shows the live level of the serial data-in line. It also holds a request bit, a read-only grant bit, and presence and size information taken from strap inputs. While the grant is held, the host drives the pins itself by rewriting the control word.

The second register starts a hardware word fetch. The host writes a word address with the start bit set. A small engine then runs a read frame on the SPI pins in mode 0 and packs the two bytes it receives into a 16-bit word. A done flag sets once the data field is valid. The engine and host bit-banging share the same pins. A pending fetch waits until the grant is gone. An inactivity timer drops a grant that the host has left idle for a set number of cycles.

Top module: `eeprom_host_if`

## Requirements
- R1: After reset, the control word (offset 0x10) reads SCK level (bit 0) = 0, chip-select level (bit 1) = 1, data-out level (bit 2) = 0, request (bit 6) = 0 and grant (bit 7) = 0. The read word (offset 0x14) reads zero. The pins are idle: spi_sck=0, spi_cs_n=1, spi_si=0.
- R2: Bit 8 of the control word shows strap_present and bits 14:11 show strap_size (a code of 7 means a 16 KB part and 8 means a 32 KB part). Both are captured in the first cycle after reset, and later strap changes are not visible.
- R3: Writing the control word with bit 6 = 1 sets request and, when no fetch is pending or running, sets grant in the same update. Writing bit 6 = 0 clears both.
- R4: While grant is 1, spi_sck, spi_cs_n and spi_si follow control bits 0, 1 and 2. While grant is 0 and no fetch runs, those bits have no effect and the pins stay idle.
- R5: Control bit 3 reads the current level of spi_so.
- R6: When grant has been held for TIMEOUT_CYC cycles with no change to control bits 2:0, the hardware clears request and grant. Any change to those bits restarts the count.
- R7: Writing the read word with bit 0 = 1 and a word address in bits 15:2 starts a frame. The frame sends opcode 0x03, then a 16-bit byte address equal to twice the word address, MSB first, with data changing while SCK is low. It then clocks in 16 bits. spi_cs_n stays low for the whole frame, which has exactly 40 SCK pulses.
- R8: The first byte received is stored in data bits 23:16 (low byte, even address) and the second byte in bits 31:24 (high byte, odd address). Bit 1 (done) sets when they are valid.
- R9: A fetch started while grant is 1 stays pending and drives no frame until grant falls. It then runs with no further host action.
- R10: Bit 0 of the read word reads 1 while a fetch is pending or running. Accepting a new start clears done.
- R11: A start written while a fetch is pending or running is ignored, and the address field keeps the first request.
- R12: Writes to any offset other than 0x10 and 0x14 change nothing, and reads of such offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| strap_present | input | 1 | EEPROM presence strap |
| strap_size | input | 4 | EEPROM size code strap |
| spi_sck | output | 1 | Serial clock to the EEPROM |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_si | output | 1 | Serial data to the EEPROM |
| spi_so | input | 1 | Serial data from the EEPROM |

## Verification
The hardest state to reach is a fetch that waits behind a live grant. The bench must hold the grant, post a start and keep the pins quiet for a while, yet stay short of the inactivity limit. It then releases the grant and follows the held request into a full frame. The inactivity limit is set low in the bench, and writes that toggle only the clock bit place the expiry at known cycle distances. A behavioural EEPROM model in the bench decodes each frame, counts SCK pulses and answers with bytes computed from the address, so byte order and address doubling are checked against independent values.

// File: rtl/eeh_pkg.sv
package eeh_pkg;
    localparam logic [7:0] OFS_CTRL = 8'h10;
    localparam logic [7:0] OFS_FETCH = 8'h14;

    // control word field positions
    localparam int C_SCK  = 0;
    localparam int C_CS   = 1;
    localparam int C_SI   = 2;
    localparam int C_SO   = 3;
    localparam int C_REQ  = 6;
    localparam int C_GNT  = 7;
    localparam int C_PRES = 8;
    localparam int C_SIZE = 11;

    // fetch word field positions
    localparam int F_START = 0;
    localparam int F_DONE  = 1;
    localparam int F_ADDR  = 2;
    localparam int F_DATA  = 16;

    localparam logic [7:0] RD_OPCODE = 8'h03;
    localparam int FRAME_BITS = 40;

    typedef struct packed {
        logic sck;
        logic cs_n;
        logic si;
    } pin_set_t;

    localparam pin_set_t PIN_IDLE = '{sck: 1'b0, cs_n: 1'b1, si: 1'b0};

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_SHIFT,
        ENG_TAIL
    } eng_state_e;
endpackage

// File: rtl/eeh_strap_capture.sv
module eeh_strap_capture #(
    parameter int SIZE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_present,
    input  logic [SIZE_W-1:0] strap_size,
    output logic              valid,
    output logic              pres,
    output logic [SIZE_W-1:0] size
);
    typedef struct packed {
        logic              taken;
        logic              pres;
        logic [SIZE_W-1:0] size;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (!cap_q.taken) begin
            cap_d.taken = 1'b1;
            cap_d.pres  = strap_present;
            cap_d.size  = strap_size;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign valid = cap_q.taken;
    assign pres  = cap_q.pres;
    assign size  = cap_q.size;
endmodule

// File: rtl/eeh_arbiter.sv
module eeh_arbiter
    import eeh_pkg::*;
#(
    parameter int TIMEOUT_CYC = 250_000_000
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ctrl_wr,
    input  logic     wr_req,
    input  pin_set_t host_pins,
    input  logic     eng_quiet,
    output logic     req,
    output logic     gnt
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

    typedef struct packed {
        logic             req;
        logic             gnt;
        logic [CNT_W-1:0] idle_cnt;
        pin_set_t         last_pins;
    } arb_t;

    arb_t arb_d, arb_q;
    logic activity;

    always_comb begin
        arb_d = arb_q;
        arb_d.last_pins = host_pins;
        activity = (host_pins != arb_q.last_pins);

        if (ctrl_wr) arb_d.req = wr_req;

        // idle timer: only runs while the host owns the pins
        if (arb_q.gnt && !activity) begin
            if (arb_q.idle_cnt == CNT_LAST) begin
                arb_d.req      = 1'b0;
                arb_d.idle_cnt = '0;
            end else begin
                arb_d.idle_cnt = arb_q.idle_cnt + 1'b1;
            end
        end else begin
            arb_d.idle_cnt = '0;
        end

        // a pending or running fetch takes precedence over a fresh grant
        arb_d.gnt = arb_d.req && (arb_q.gnt || eng_quiet);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arb_q <= '{req: 1'b0, gnt: 1'b0, idle_cnt: '0, last_pins: PIN_IDLE};
        end else begin
            arb_q <= arb_d;
        end
    end

    assign req = arb_q.req;
    assign gnt = arb_q.gnt;
endmodule

// File: rtl/eeh_read_engine.sv
module eeh_read_engine
    import eeh_pkg::*;
#(
    parameter int SCK_HALF = 4,
    parameter int WADDR_W  = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic [WADDR_W-1:0] word_addr,
    input  logic               spi_so,
    output pin_set_t           pins,
    output logic               busy,
    output logic               done,
    output logic [15:0]        data_word
);
    localparam int DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCK_HALF - 1);
    localparam int BIT_W = $clog2(FRAME_BITS);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

    typedef struct packed {
        eng_state_e       st;
        logic             high;
        logic [DIV_W-1:0] div;
        logic [BIT_W-1:0] bits;
        logic [23:0]      tx;
        logic [15:0]      rx;
        pin_set_t         pins;
        logic             done;
    } eng_t;

    eng_t eng_d, eng_q;
    logic [15:0] byte_addr;

    assign byte_addr = 16'({word_addr, 1'b0});

    always_comb begin
        eng_d = eng_q;
        eng_d.done = 1'b0;
        unique case (eng_q.st)
            ENG_IDLE: begin
                eng_d.pins = PIN_IDLE;
                if (launch) begin
                    eng_d.st   = ENG_SHIFT;
                    eng_d.high = 1'b0;
                    eng_d.div  = '0;
                    eng_d.bits = '0;
                    eng_d.tx   = {RD_OPCODE, byte_addr};
                    eng_d.pins = '{sck: 1'b0, cs_n: 1'b0, si: RD_OPCODE[7]};
                end
            end
            ENG_SHIFT: begin
                if (eng_q.div == DIV_LAST) begin
                    eng_d.div = '0;
                    if (!eng_q.high) begin
                        // rising edge: sample the device output
                        eng_d.high     = 1'b1;
                        eng_d.pins.sck = 1'b1;
                        eng_d.rx       = {eng_q.rx[14:0], spi_so};
                    end else begin
                        // falling edge: present the next output bit
                        eng_d.high     = 1'b0;
                        eng_d.pins.sck = 1'b0;
                        eng_d.bits     = eng_q.bits + 1'b1;
                        eng_d.tx       = {eng_q.tx[22:0], 1'b0};
                        eng_d.pins.si  = eng_q.tx[22];
                        if (eng_q.bits == BIT_LAST) begin
                            eng_d.st      = ENG_TAIL;
                            eng_d.pins.si = 1'b0;
                        end
                    end
                end else begin
                    eng_d.div = eng_q.div + 1'b1;
                end
            end
            ENG_TAIL: begin
                if (eng_q.div == DIV_LAST) begin
                    eng_d.div  = '0;
                    eng_d.st   = ENG_IDLE;
                    eng_d.pins = PIN_IDLE;
                    eng_d.done = 1'b1;
                end else begin
                    eng_d.div = eng_q.div + 1'b1;
                end
            end
            default: eng_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: ENG_IDLE, high: 1'b0, div: '0, bits: '0, tx: '0,
                       rx: '0, pins: PIN_IDLE, done: 1'b0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign pins      = eng_q.pins;
    assign busy      = (eng_q.st != ENG_IDLE);
    assign done      = eng_q.done;
    // first byte in (even address) lands low, second byte high
    assign data_word = {eng_q.rx[7:0], eng_q.rx[15:8]};
endmodule

// File: rtl/eeprom_host_if.sv
module eeprom_host_if
    import eeh_pkg::*;
#(
    parameter int TIMEOUT_CYC = 250_000_000,
    parameter int SCK_HALF    = 4,
    parameter int WADDR_W     = 14
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        strap_present,
    input  logic [3:0]  strap_size,
    output logic        spi_sck,
    output logic        spi_cs_n,
    output logic        spi_si,
    input  logic        spi_so
);
    localparam int SIZE_W = 4;

    typedef struct packed {
        pin_set_t           host;
        logic               pending;
        logic               done;
        logic [WADDR_W-1:0] waddr;
        logic [15:0]        data;
    } top_t;

    top_t st_d, st_q;

    logic              wr_ctrl, wr_fetch, launch;
    logic              req, gnt;
    logic              eng_busy, eng_done;
    logic [15:0]       eng_data;
    pin_set_t          eng_pins, pin_out;
    logic              strap_valid, pres;
    logic [SIZE_W-1:0] size_code;
    logic              rd_done;

    assign wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_fetch = bus_wr && (bus_addr == OFS_FETCH);
    assign launch   = st_q.pending && !gnt;
    assign rd_done  = st_q.done;

    eeh_strap_capture #(.SIZE_W(SIZE_W)) u_strap (
        .clk           (clk),
        .rst_n         (rst_n),
        .strap_present (strap_present),
        .strap_size    (strap_size),
        .valid         (strap_valid),
        .pres          (pres),
        .size          (size_code)
    );

    eeh_arbiter #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (wr_ctrl),
        .wr_req    (bus_wdata[C_REQ]),
        .host_pins (st_q.host),
        .eng_quiet (!eng_busy && !st_q.pending),
        .req       (req),
        .gnt       (gnt)
    );

    eeh_read_engine #(.SCK_HALF(SCK_HALF), .WADDR_W(WADDR_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .word_addr (st_q.waddr),
        .spi_so    (spi_so),
        .pins      (eng_pins),
        .busy      (eng_busy),
        .done      (eng_done),
        .data_word (eng_data)
    );

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.host = '{sck: bus_wdata[C_SCK], cs_n: bus_wdata[C_CS], si: bus_wdata[C_SI]};
        end
        if (launch) st_d.pending = 1'b0;
        if (eng_done) begin
            st_d.done = 1'b1;
            st_d.data = eng_data;
        end
        if (wr_fetch && bus_wdata[F_START] && !st_q.pending && !eng_busy) begin
            st_d.pending = 1'b1;
            st_d.done    = 1'b0;
            st_d.waddr   = bus_wdata[F_ADDR +: WADDR_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{host: PIN_IDLE, pending: 1'b0, done: 1'b0, waddr: '0, data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_out  = gnt ? st_q.host : eng_pins;
    assign spi_sck  = pin_out.sck;
    assign spi_cs_n = pin_out.cs_n;
    assign spi_si   = pin_out.si;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[C_SCK]  = st_q.host.sck;
                bus_rdata[C_CS]   = st_q.host.cs_n;
                bus_rdata[C_SI]   = st_q.host.si;
                bus_rdata[C_SO]   = spi_so;
                bus_rdata[C_REQ]  = req;
                bus_rdata[C_GNT]  = gnt;
                bus_rdata[C_PRES] = pres;
                bus_rdata[C_SIZE +: SIZE_W] = size_code;
            end
            OFS_FETCH: begin
                bus_rdata[F_START] = st_q.pending || eng_busy;
                bus_rdata[F_DONE]  = st_q.done;
                bus_rdata[F_ADDR +: WADDR_W] = st_q.waddr;
                bus_rdata[F_DATA +: 16] = st_q.data;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/eeh_checker.sv
module eeh_checker #(
    parameter int TIMEOUT_CYC = 250_000_000
) (
    input logic clk,
    input logic rst_n,
    input logic req,
    input logic gnt,
    input logic eng_busy,
    input logic rd_done,
    input logic strap_valid,
    input logic pres,
    input logic spi_sck,
    input logic spi_cs_n,
    input logic spi_si
);
    logic [31:0] quiet_cnt;
    logic [2:0]  prev_pins;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_cnt <= '0;
            prev_pins <= 3'b010;
        end else begin
            prev_pins <= {spi_sck, spi_cs_n, spi_si};
            if (!gnt || ({spi_sck, spi_cs_n, spi_si} != prev_pins)) quiet_cnt <= '0;
            else quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    // R3
    gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n) gnt |-> req);

    // R9
    no_shared_pins_chk: assert property (@(posedge clk) disable iff (!rst_n) !(gnt && eng_busy));

    // R4
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt && !eng_busy) |-> (spi_cs_n && !spi_sck));

    // R7
    frame_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> !spi_cs_n);

    // R8
    done_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_done) |-> !eng_busy);

    // R6
    grant_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_cnt <= 32'(TIMEOUT_CYC + 1));

    // R2
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_valid && $past(strap_valid)) |-> $stable(pres));
endmodule

bind eeprom_host_if eeh_checker #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .gnt         (gnt),
    .eng_busy    (eng_busy),
    .rd_done     (rd_done),
    .strap_valid (strap_valid),
    .pres        (pres),
    .spi_sck     (spi_sck),
    .spi_cs_n    (spi_cs_n),
    .spi_si      (spi_si)
);

// File: tb/eeprom_host_if_test.sv
module eeprom_host_if_test;
    localparam int TMO  = 100;
    localparam int HALF = 2;
    localparam logic [7:0] A_CTRL = 8'h10;
    localparam logic [7:0] A_FETCH = 8'h14;
    localparam int NVEC = 8;
    localparam logic [13:0] VEC [NVEC] = '{14'h0000, 14'h0001, 14'h0002, 14'h0155,
                                           14'h2AAA, 14'h3FFF, 14'h0100, 14'h007F};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        strap_present = 1'b1;
    logic [3:0]  strap_size = 4'd7;
    logic        spi_sck, spi_cs_n, spi_si, spi_so;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // EEPROM model state
    int          m_cnt = 0;
    int          m_pulses = 0;
    int          m_frames = 0;
    logic [23:0] m_sh = '0;
    logic        m_so = 1'b0;
    logic        so_force_en = 1'b0;
    logic        so_force = 1'b0;

    assign spi_so = so_force_en ? so_force : m_so;

    always #4 clk = ~clk;

    eeprom_host_if #(.TIMEOUT_CYC(TMO), .SCK_HALF(HALF), .WADDR_W(14)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .strap_present(strap_present),
        .strap_size(strap_size), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_si(spi_si), .spi_so(spi_so)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] * 8'd37 + a[15:8] * 8'd5 + 8'h1B;
    endfunction

    always @(negedge spi_cs_n) begin
        m_cnt = 0;
        m_pulses = 0;
        m_so = 1'b0;
    end
    always @(posedge spi_cs_n) m_frames = m_frames + 1;
    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            m_pulses = m_pulses + 1;
            if (m_cnt < 24) m_sh = {m_sh[22:0], spi_si};
            m_cnt = m_cnt + 1;
        end
    end
    always @(negedge spi_sck) begin
        if (!spi_cs_n && m_cnt >= 24 && m_cnt < 40) begin
            automatic int k = m_cnt - 24;
            automatic logic [7:0] b = (k < 8) ? mem_byte(m_sh[15:0]) : mem_byte(m_sh[15:0] + 16'd1);
            m_so = b[7 - (k % 8)];
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_done(output logic ok);
        logic [31:0] v;
        ok = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            bus_read(A_FETCH, v);
            if (v[1]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [31:0] v;
        logic ok;
        int fr;
        logic [15:0] expw;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 / R2 reset state and strap capture (7 -> 16 KB code)
        bus_read(A_CTRL, v);
        check("R1 R2 ctrl reset", v, 32'h0000_3902);
        bus_read(A_FETCH, v);
        check("R1 fetch reset", v, 32'h0);
        check("R1 pins idle", {29'd0, spi_sck, spi_cs_n, spi_si}, 32'h2);
        strap_present = 1'b0; strap_size = 4'd8;
        repeat (3) @(negedge clk);
        bus_read(A_CTRL, v);
        check("R2 straps held", v, 32'h0000_3902);

        // R12 unmapped offset
        bus_write(8'h20, 32'hFFFF_FFFF);
        bus_read(8'h20, v);
        check("R12 unmapped read", v, 32'h0);
        bus_read(A_CTRL, v);
        check("R12 ctrl untouched", v, 32'h0000_3902);

        // R7 R8 R10 vector walk
        for (int i = 0; i < NVEC; i++) begin
            fr = m_frames;
            bus_write(A_FETCH, {16'h0, VEC[i], 2'b01});
            bus_read(A_FETCH, v);
            check("R10 start busy", {31'd0, v[0]}, 32'd1);
            check("R10 done cleared", {31'd0, v[1]}, 32'd0);
            wait_done(ok);
            check("R8 done seen", {31'd0, ok}, 32'd1);
            bus_read(A_FETCH, v);
            expw = {mem_byte(16'({VEC[i], 1'b1})), mem_byte(16'({VEC[i], 1'b0}))};
            check("R8 data word", {16'd0, v[31:16]}, {16'd0, expw});
            check("R7 address field", {18'd0, v[15:2]}, {18'd0, VEC[i]});
            check("R7 opcode", {24'd0, m_sh[23:16]}, 32'h03);
            check("R7 byte address", {16'd0, m_sh[15:0]}, {16'd0, 16'({VEC[i], 1'b0})});
            check("R7 pulse count", 32'(m_pulses), 32'd40);
            check("R7 single frame", 32'(m_frames - fr), 32'd1);
        end

        // R11 start while busy is ignored
        fr = m_frames;
        bus_write(A_FETCH, {16'h0, 14'h0123, 2'b01});
        bus_write(A_FETCH, {16'h0, 14'h0456, 2'b01});
        bus_read(A_FETCH, v);
        check("R11 address kept", {18'd0, v[15:2]}, 32'h123);
        wait_done(ok);
        repeat (4) @(negedge clk);
        check("R11 one frame", 32'(m_frames - fr), 32'd1);
        check("R11 frame address", {16'd0, m_sh[15:0]}, 32'h0246);

        // R3 request and grant
        bus_write(A_CTRL, 32'h0000_0042);
        bus_read(A_CTRL, v);
        check("R3 grant set", {30'd0, v[7:6]}, 32'd3);
        // R4 pins follow host bits
        bus_write(A_CTRL, 32'h0000_0045);
        check("R4 host pins", {29'd0, spi_sck, spi_cs_n, spi_si}, 32'h5);
        // R5 data-in readback
        so_force_en = 1'b1; so_force = 1'b1;
        bus_read(A_CTRL, v);
        check("R5 so high", {31'd0, v[3]}, 32'd1);
        so_force = 1'b0;
        bus_read(A_CTRL, v);
        check("R5 so low", {31'd0, v[3]}, 32'd0);
        so_force_en = 1'b0;

        // R9 fetch held while granted
        fr = m_frames;
        bus_write(A_FETCH, {16'h0, 14'h0005, 2'b01});
        repeat (20) @(negedge clk);
        bus_read(A_FETCH, v);
        check("R9 pending shown", {30'd0, v[1:0]}, 32'd1);
        check("R9 pins still host", {29'd0, spi_sck, spi_cs_n, spi_si}, 32'h5);
        check("R9 no frame", 32'(m_frames - fr), 32'd0);
        bus_write(A_CTRL, 32'h0000_0002);
        bus_read(A_CTRL, v);
        check("R3 release clears", {30'd0, v[7:6]}, 32'd0);
        wait_done(ok);
        bus_read(A_FETCH, v);
        check("R9 held fetch data", {16'd0, v[31:16]}, {16'd0, mem_byte(16'd11), mem_byte(16'd10)});

        // R4 host bits ignored without grant
        bus_write(A_CTRL, 32'h0000_0005);
        check("R4 no grant idle", {29'd0, spi_sck, spi_cs_n, spi_si}, 32'h2);

        // R6 inactivity timeout
        bus_write(A_CTRL, 32'h0000_0042);
        repeat (50) @(negedge clk);
        bus_write(A_CTRL, 32'h0000_0043);
        repeat (80) @(negedge clk);
        bus_read(A_CTRL, v);
        check("R6 activity restarts", {30'd0, v[7:6]}, 32'd3);
        repeat (40) @(negedge clk);
        bus_read(A_CTRL, v);
        check("R6 timeout clears", {30'd0, v[7:6]}, 32'd0);
        check("R6 pins idle", {29'd0, spi_sck, spi_cs_n, spi_si}, 32'h2);

        finished = 1;
        summary();
    end
endmodule